// File: doc/BRIEF.md
# Twin Predicate Element Sequencer

This block walks the element positions of one vector operation under two independent predicate masks, one for the source side and one for the destination side. After a start pulse it produces one pairing per clock: a source element index, a destination element index, a valid strobe and two zero indications. A downstream execution stage uses each pairing to read one source element and write one destination element. Because the two sides step separately through their own enabled bits, the same walk gives compress, expand, scalar insert and extract behaviour, with no special opcodes.

Each mask comes from a shared kind bit and its own 3-bit code. Kind 0 builds the mask from the contents of three integer registers (called R3, R10 and R30 here). Kind 1 tests one chosen bit of consecutive condition fields taken from a packed vector of 64 four-bit fields, starting at field 32. All mode inputs, register contents and the vector length are captured on the start pulse and held for the whole walk. The walk ends as soon as either side runs out of enabled positions below the vector length. A one-cycle done pulse marks the end.

Top module: `twin_pred_seq`

## Requirements
- R1: With kind 0, element i of a mask is enabled as follows: code 000 enables every element; code 001 enables only the element whose index equals the full 64-bit value of R3, so an R3 of 64 or more enables nothing; codes 010, 100 and 110 enable element i when bit i of R3, R10 or R30 is 1; codes 011, 101 and 111 enable it when that bit is 0.
- R2: With kind 1, element i tests condition field 32+i, which sits at `crFields[4*(32+i)+3 : 4*(32+i)]` with bit 3 = LT, bit 2 = GT, bit 1 = EQ and bit 0 = SO. Code bits [2:1] pick the flag (00 LT, 01 GT, 10 EQ, 11 SO). Code bit 0 = 0 enables on a set flag and 1 enables on a clear flag. Fields past index 63 read as all zero.
- R3: One kind bit governs both masks, so the source and destination masks are always of the same kind.
- R4: With `srcZero` = 0, source indices are the enabled source positions in ascending order, each used once. Disabled positions are skipped, and `srcZeroFlag` stays 0.
- R5: With `srcZero` = 1, every source position from 0 upward is used in order. A position whose mask bit is 0 is reported with `srcZeroFlag` = 1.
- R6: With `dstZero` = 1, every destination position from 0 upward is emitted in order. A disabled position carries `dstZeroFlag` = 1 and does not use up a source element, so the next pairing repeats the same source index.
- R7: With `dstZero` = 0, destination indices are the enabled destination positions in ascending order, and disabled positions are never emitted.
- R8: A vector length of 0 emits no pairing. Done pulses one cycle after the edge that takes the start.
- R9: Out of reset, and whenever idle, `elemValid`, `busy` and `done` are 0. The walk ends when either side has no usable position left below the vector length. `done` is then high for exactly one cycle and `busy` is low in that same cycle.
- R10: Pairings come one per clock with no gaps. Pairing n is visible in the cycle after edge k+1+n, where k is the edge that takes the start. Done follows in the cycle right after the last pairing. Every emitted index is below the vector length.
- R11: A start pulse while busy is ignored. Changes to codes, registers, condition fields or length during a walk do not alter it.
- R12: A vector length above 64 acts as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vecLen | input | 7 | Vector length |
| maskKind | input | 1 | 0 = integer-register masks, 1 = condition-field masks |
| srcCode | input | 3 | Source mask code |
| dstCode | input | 3 | Destination mask code |
| regR3 | input | 64 | Contents of R3 |
| regR10 | input | 64 | Contents of R10 |
| regR30 | input | 64 | Contents of R30 |
| crFields | input | 256 | 64 condition fields, field f at bits 4f+3..4f |
| srcZero | input | 1 | Source zeroing enable |
| dstZero | input | 1 | Destination zeroing enable |
| elemValid | output | 1 | A pairing is presented this cycle |
| srcIdx | output | 6 | Source element index |
| dstIdx | output | 6 | Destination element index |
| srcZeroFlag | output | 1 | Source element reads as zero |
| dstZeroFlag | output | 1 | Destination element is written with zero |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Pairing n is due in the cycle after edge k+1+n and done in the cycle after edge k+1+N, where k is the edge that takes the start and N is the count of pairings. The bench therefore drops start after edge k and then samples once per cycle on the falling edge. At each sample it compares the slot number against the pairing count, so a late, early or gapped pairing fails as surely as a wrong index. The expected pairing list is computed before each start from the mask rules and the stepping rules. That list stays fixed when start is pulsed again or the inputs are changed mid-walk, which exposes any leak of live inputs into a running walk.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic load;    // capture lengths, masks and zeroing bits
    logic step;    // emit one pairing and advance positions
    logic finish;  // raise done
  } tps_strobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tps_state_e;

endpackage

// File: rtl/tps_mask_gen.sv
module tps_mask_gen #(
  parameter int MAX_VL  = 64,
  parameter int REG_W   = 64,
  parameter int NUM_CR  = 64,
  parameter int CR_BASE = 32
) (
  input  logic                  kind,
  input  logic [2:0]            code,
  input  logic [REG_W-1:0]      r3,
  input  logic [REG_W-1:0]      r10,
  input  logic [REG_W-1:0]      r30,
  input  logic [4*NUM_CR-1:0]   crFields,
  output logic [MAX_VL-1:0]     mask
);

  logic [REG_W-1:0] intSrc;

  always_comb begin
    case (code[2:1])
      2'b01:   intSrc = r3;
      2'b10:   intSrc = r10;
      2'b11:   intSrc = r30;
      default: intSrc = '0;
    endcase
  end

  generate
    if (CR_BASE > 0) begin : g_low_fields
      logic unusedLowFields;
      assign unusedLowFields = ^crFields[4*CR_BASE-1:0];
    end

    for (genvar i = 0; i < MAX_VL; i++) begin : g_elem
      logic       regBit;
      logic       intBit;
      logic [3:0] fld;
      logic       flagBit;

      if (i < REG_W) begin : g_reg
        assign regBit = intSrc[i];
      end else begin : g_noreg
        assign regBit = 1'b0;
      end

      if (CR_BASE + i < NUM_CR) begin : g_fld
        assign fld = crFields[4*(CR_BASE+i) +: 4];
      end else begin : g_nofld
        assign fld = 4'h0;
      end

      always_comb begin
        case (code)
          3'b000:  intBit = 1'b1;
          3'b001:  intBit = (r3 == REG_W'(i));
          default: intBit = regBit ^ code[0];
        endcase
      end

      always_comb begin
        case (code[2:1])
          2'b00:   flagBit = fld[3];
          2'b01:   flagBit = fld[2];
          2'b10:   flagBit = fld[1];
          default: flagBit = fld[0];
        endcase
      end

      assign mask[i] = kind ? (flagBit ^ code[0]) : intBit;
    end
  endgenerate

endmodule

// File: rtl/tps_seek.sv
module tps_seek #(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic [MAX_VL-1:0] mask,
  input  logic [VLW-1:0]    fromPos,
  input  logic [VLW-1:0]    limit,
  input  logic              takeAll,
  output logic              hit,
  output logic [VLW-1:0]    cand
);

  // lowest usable position at or above fromPos and below limit
  always_comb begin
    hit  = 1'b0;
    cand = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if ((takeAll ? (VLW'(i) == fromPos) : mask[i]) &&
          (VLW'(i) >= fromPos) && (VLW'(i) < limit)) begin
        hit  = 1'b1;
        cand = VLW'(i);
      end
    end
  end

endmodule

// File: rtl/tps_datapath.sv
module tps_datapath
  import tps_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VLW    = $clog2(MAX_VL + 1),
  parameter int IW     = $clog2(MAX_VL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tps_strobe_t        strobe,
  input  logic [VLW-1:0]     vecLen,
  input  logic [MAX_VL-1:0]  srcMaskIn,
  input  logic [MAX_VL-1:0]  dstMaskIn,
  input  logic               szIn,
  input  logic               dzIn,
  output logic               srcHit,
  output logic               dstHit,
  output logic               elemValid,
  output logic [IW-1:0]      srcIdx,
  output logic [IW-1:0]      dstIdx,
  output logic               srcZeroFlag,
  output logic               dstZeroFlag,
  output logic               done
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);

  logic [VLW-1:0]    vlReg;
  logic [MAX_VL-1:0] srcMaskR;
  logic [MAX_VL-1:0] dstMaskR;
  logic              szR;
  logic              dzR;
  logic [VLW-1:0]    srcPos;
  logic [VLW-1:0]    dstPos;
  logic [VLW-1:0]    srcCand;
  logic [VLW-1:0]    dstCand;
  logic              srcZeroNow;
  logic              dstZeroNow;

  tps_seek #(.MAX_VL(MAX_VL), .VLW(VLW)) i_seek_src (
    .mask(srcMaskR), .fromPos(srcPos), .limit(vlReg), .takeAll(szR),
    .hit(srcHit), .cand(srcCand)
  );

  tps_seek #(.MAX_VL(MAX_VL), .VLW(VLW)) i_seek_dst (
    .mask(dstMaskR), .fromPos(dstPos), .limit(vlReg), .takeAll(dzR),
    .hit(dstHit), .cand(dstCand)
  );

  assign srcZeroNow = szR & ~srcMaskR[srcCand[IW-1:0]];
  assign dstZeroNow = dzR & ~dstMaskR[dstCand[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlReg       <= '0;
      srcMaskR    <= '0;
      dstMaskR    <= '0;
      szR         <= 1'b0;
      dzR         <= 1'b0;
      srcPos      <= '0;
      dstPos      <= '0;
      elemValid   <= 1'b0;
      srcIdx      <= '0;
      dstIdx      <= '0;
      srcZeroFlag <= 1'b0;
      dstZeroFlag <= 1'b0;
      done        <= 1'b0;
    end else begin
      elemValid <= 1'b0;
      done      <= 1'b0;
      if (strobe.load) begin
        vlReg    <= (vecLen > VL_CAP) ? VL_CAP : vecLen;
        srcMaskR <= srcMaskIn;
        dstMaskR <= dstMaskIn;
        szR      <= szIn;
        dzR      <= dzIn;
        srcPos   <= '0;
        dstPos   <= '0;
      end
      if (strobe.step) begin
        elemValid   <= 1'b1;
        srcIdx      <= srcCand[IW-1:0];
        dstIdx      <= dstCand[IW-1:0];
        srcZeroFlag <= srcZeroNow;
        dstZeroFlag <= dstZeroNow;
        dstPos      <= dstCand + 1'b1;
        if (!dstZeroNow) srcPos <= srcCand + 1'b1;
      end
      if (strobe.finish) done <= 1'b1;
    end
  end

  // R10: emitted indices stay below the captured length
  p_idx_in_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    elemValid |-> ((VLW'(srcIdx) < vlReg) && (VLW'(dstIdx) < vlReg)));

  // R7: destination indices strictly rise within a walk
  p_dst_rising_r7: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && $past(elemValid)) |-> (dstIdx > $past(dstIdx)));

  // R7: a non-zeroed destination is always an enabled one
  p_dst_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && !dstZeroFlag) |-> dstMaskR[dstIdx]);

  // R4: without source zeroing, the source is enabled and never flagged
  p_src_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && !szR) |-> (srcMaskR[srcIdx] && !srcZeroFlag));

  // R9: done never coincides with a pairing
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !elemValid);

  // R8: an empty length gives no usable pair right after capture
  p_empty_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (vecLen == '0)) |=> !(srcHit && dstHit));

endmodule

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        srcHit,
  input  logic        dstHit,
  output tps_strobe_t strobe,
  output logic        busy
);

  tps_state_e state;
  tps_state_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (srcHit && dstHit) begin
          strobe.step = 1'b1;
        end else begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);

  // R9: the finishing cycle drops busy on the next edge
  p_finish_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !busy);

  // R11: a start seen mid-walk neither reloads nor ends the walk
  p_start_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !strobe.finish) |=> (busy && !strobe.load));

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import tps_pkg::*;
#(
  parameter int MAX_VL  = 64,
  parameter int REG_W   = 64,
  parameter int NUM_CR  = 64,
  parameter int CR_BASE = 32,
  localparam int VLW    = $clog2(MAX_VL + 1),
  localparam int IW     = $clog2(MAX_VL)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [VLW-1:0]      vecLen,
  input  logic                maskKind,
  input  logic [2:0]          srcCode,
  input  logic [2:0]          dstCode,
  input  logic [REG_W-1:0]    regR3,
  input  logic [REG_W-1:0]    regR10,
  input  logic [REG_W-1:0]    regR30,
  input  logic [4*NUM_CR-1:0] crFields,
  input  logic                srcZero,
  input  logic                dstZero,
  output logic                elemValid,
  output logic [IW-1:0]       srcIdx,
  output logic [IW-1:0]       dstIdx,
  output logic                srcZeroFlag,
  output logic                dstZeroFlag,
  output logic                busy,
  output logic                done
);

  tps_strobe_t       strobe;
  logic              srcHit;
  logic              dstHit;
  logic [MAX_VL-1:0] srcMask;
  logic [MAX_VL-1:0] dstMask;

  tps_mask_gen #(.MAX_VL(MAX_VL), .REG_W(REG_W), .NUM_CR(NUM_CR), .CR_BASE(CR_BASE))
  i_mask_src (
    .kind(maskKind), .code(srcCode), .r3(regR3), .r10(regR10), .r30(regR30),
    .crFields(crFields), .mask(srcMask)
  );

  tps_mask_gen #(.MAX_VL(MAX_VL), .REG_W(REG_W), .NUM_CR(NUM_CR), .CR_BASE(CR_BASE))
  i_mask_dst (
    .kind(maskKind), .code(dstCode), .r3(regR3), .r10(regR10), .r30(regR30),
    .crFields(crFields), .mask(dstMask)
  );

  tps_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcHit(srcHit), .dstHit(dstHit),
    .strobe(strobe), .busy(busy)
  );

  tps_datapath #(.MAX_VL(MAX_VL), .VLW(VLW), .IW(IW)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecLen(vecLen),
    .srcMaskIn(srcMask), .dstMaskIn(dstMask), .szIn(srcZero), .dzIn(dstZero),
    .srcHit(srcHit), .dstHit(dstHit), .elemValid(elemValid),
    .srcIdx(srcIdx), .dstIdx(dstIdx), .srcZeroFlag(srcZeroFlag),
    .dstZeroFlag(dstZeroFlag), .done(done)
  );

endmodule

// File: tb/test_twin_pred_seq.sv
module test_twin_pred_seq;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   vecLen = '0;
  logic         maskKind = 1'b0;
  logic [2:0]   srcCode = '0;
  logic [2:0]   dstCode = '0;
  logic [63:0]  regR3 = '0;
  logic [63:0]  regR10 = '0;
  logic [63:0]  regR30 = '0;
  logic [255:0] crFields = '0;
  logic         srcZero = 1'b0;
  logic         dstZero = 1'b0;
  logic         elemValid;
  logic [5:0]   srcIdx;
  logic [5:0]   dstIdx;
  logic         srcZeroFlag;
  logic         dstZeroFlag;
  logic         busy;
  logic         done;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  int eSrc[64];
  int eDst[64];
  bit eSz[64];
  bit eDz[64];
  int eN;

  always #2 clk = ~clk;

  twin_pred_seq i_twin_pred_seq (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .maskKind(maskKind),
    .srcCode(srcCode), .dstCode(dstCode), .regR3(regR3), .regR10(regR10),
    .regR30(regR30), .crFields(crFields), .srcZero(srcZero), .dstZero(dstZero),
    .elemValid(elemValid), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .srcZeroFlag(srcZeroFlag), .dstZeroFlag(dstZeroFlag), .busy(busy), .done(done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nFails++;
      $display("FAIL R10 watchdog expired: actual=%0d expected<=190000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mask from the kind/code rules of R1 and R2
  function automatic logic [63:0] buildMask(input logic [2:0] code);
    logic [63:0] m;
    logic [63:0] rv;
    logic [3:0]  fld;
    logic        b;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (!maskKind) begin
        case (code[2:1])
          2'd1:    rv = regR3;
          2'd2:    rv = regR10;
          2'd3:    rv = regR30;
          default: rv = '0;
        endcase
        if (code == 3'd0)      m[i] = 1'b1;
        else if (code == 3'd1) m[i] = (regR3 == 64'(i));
        else                   m[i] = rv[i] ^ code[0];
      end else begin
        if (32 + i < 64) fld = crFields[4*(32+i) +: 4];
        else             fld = 4'h0;
        case (code[2:1])
          2'd0:    b = fld[3];
          2'd1:    b = fld[2];
          2'd2:    b = fld[1];
          default: b = fld[0];
        endcase
        m[i] = b ^ code[0];
      end
    end
    return m;
  endfunction

  // expected pairing list from the stepping rules R4..R7, R12
  task automatic computeExp();
    logic [63:0] sm;
    logic [63:0] dm;
    int vl, sp, dp, sc, dc;
    bit dflag;
    sm = buildMask(srcCode);
    dm = buildMask(dstCode);
    vl = (vecLen > 7'd64) ? 64 : int'(vecLen);
    sp = 0; dp = 0; eN = 0;
    while (1) begin
      sc = -1; dc = -1;
      for (int i = sp; i < vl; i++) if (srcZero || sm[i]) begin sc = i; break; end
      for (int i = dp; i < vl; i++) if (dstZero || dm[i]) begin dc = i; break; end
      if (sc < 0 || dc < 0) break;
      dflag = dstZero && !dm[dc];
      eSrc[eN] = sc;
      eDst[eN] = dc;
      eSz[eN]  = srcZero && !sm[sc];
      eDz[eN]  = dflag;
      eN++;
      dp = dc + 1;
      if (!dflag) sp = sc + 1;
    end
  endtask

  // disturb = 1: pulse start and alter inputs during the walk (R11)
  task automatic runOne(input string req, input bit disturb);
    int c, n;
    bit gotDone;
    computeExp();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 0; n = 0; gotDone = 0;
    while (!gotDone && c < 200) begin
      @(posedge clk);
      @(negedge clk);
      if (elemValid) begin
        check(c == n, req, "R10 pairing slot", c, n);
        check(n < eN, req, "pairing count overrun", n, eN);
        if (n < eN) begin
          check(int'(srcIdx) == eSrc[n], req, "srcIdx", int'(srcIdx), eSrc[n]);
          check(int'(dstIdx) == eDst[n], req, "dstIdx", int'(dstIdx), eDst[n]);
          check(srcZeroFlag == eSz[n], req, "srcZeroFlag", int'(srcZeroFlag), int'(eSz[n]));
          check(dstZeroFlag == eDz[n], req, "dstZeroFlag", int'(dstZeroFlag), int'(eDz[n]));
        end
        n++;
      end
      if (done) begin
        gotDone = 1;
        check(n == eN, req, "R9 pairings before done", n, eN);
        check(c == eN, req, "R10 done slot", c, eN);
        check(!busy, req, "R9 busy low with done", int'(busy), 0);
      end else begin
        check(busy, req, "R9 busy during walk", int'(busy), 1);
      end
      if (disturb && c == 1) begin
        start    = 1'b1;
        vecLen   = 7'd3;
        regR10   = ~regR10;
        regR30   = ~regR30;
        crFields = ~crFields;
        srcCode  = srcCode ^ 3'd1;
      end
      if (disturb && c == 2) start = 1'b0;
      c++;
    end
    check(gotDone, req, "R9 done seen", int'(gotDone), 1);
    @(posedge clk);
    @(negedge clk);
    check(!done && !elemValid && !busy, req, "R9 idle after done",
          int'({done, elemValid, busy}), 0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!elemValid && !busy && !done, "R9", "reset state",
          int'({elemValid, busy, done}), 0);
    rstN = 1'b1;

    regR3    = 64'd9;
    regR10   = 64'hA5F0_0C31_8E27_4B96;
    regR30   = 64'h0123_4567_89AB_CDEF;
    crFields = {64'h9C3E_51A7_F028_6BD4, 64'h36A1_E9F0_4C7B_28D5,
                64'h7E41_B0C9_25DA_836F, 64'hD02B_6F94_A1E7_3C58};

    // compress: sparse source, all destinations
    maskKind = 0; srcCode = 3'b100; dstCode = 3'b000; srcZero = 0; dstZero = 0; vecLen = 64;
    runOne("R4 compress", 0);
    // expand: all sources, sparse destinations
    srcCode = 3'b000; dstCode = 3'b100;
    runOne("R7 expand", 0);
    // splat/extract from the R3 index
    regR3 = 64'd5; srcCode = 3'b001; dstCode = 3'b000;
    runOne("R1 splat from R3 index", 0);
    // insert into the R3 index
    srcCode = 3'b000; dstCode = 3'b001;
    runOne("R1 insert at R3 index", 0);
    // R3 index out of range enables nothing
    regR3 = 64'd70; srcCode = 3'b001;
    runOne("R1 R3 index out of range", 0);
    regR3 = 64'd9;
    // source zeroing
    srcCode = 3'b110; dstCode = 3'b000; srcZero = 1; dstZero = 0; vecLen = 20;
    runOne("R5 source zeroing", 0);
    // destination zeroing
    srcCode = 3'b101; dstCode = 3'b011; srcZero = 0; dstZero = 1; vecLen = 20;
    runOne("R6 destination zeroing", 0);
    // condition-field masks
    maskKind = 1; srcCode = 3'b010; dstCode = 3'b101; srcZero = 0; dstZero = 0; vecLen = 64;
    runOne("R2 condition field masks", 0);
    // empty length
    maskKind = 0; srcCode = 3'b000; dstCode = 3'b000; vecLen = 0;
    runOne("R8 zero length", 0);
    // over-long length clamps to 64
    vecLen = 7'd100;
    runOne("R12 length clamp", 0);
    // start and input changes during a walk
    srcCode = 3'b100; dstCode = 3'b000; vecLen = 40;
    runOne("R11 mid-walk disturbance", 1);
    regR10   = 64'hA5F0_0C31_8E27_4B96;
    regR30   = 64'h0123_4567_89AB_CDEF;
    crFields = {64'h9C3E_51A7_F028_6BD4, 64'h36A1_E9F0_4C7B_28D5,
                64'h7E41_B0C9_25DA_836F, 64'hD02B_6F94_A1E7_3C58};

    // sweep: both kinds, every code pair, every zeroing combination
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 8; s++) begin
        for (int d = 0; d < 8; d++) begin
          for (int z = 0; z < 4; z++) begin
            for (int v = 0; v < 3; v++) begin
              maskKind = k[0];
              srcCode  = s[2:0];
              dstCode  = d[2:0];
              srcZero  = z[0];
              dstZero  = z[1];
              vecLen   = (v == 0) ? 7'd0 : ((v == 1) ? 7'd7 : 7'd64);
              runOne("R3 sweep", 0);
            end
          end
        end
      end
    end

    summary();
    $finish;
  end

endmodule